// File: doc/BRIEF.md
# Fixed-Rate Access Launcher with Dummy Fill

This block sits between a single requester, such as a cache miss path, and a shared resource, such as an external memory port. Once a session is started, it launches one resource access per epoch on a schedule that depends only on a programmed interval and the resource's completion timing, never on what the requester does. When a request is waiting at the moment of launch, that access carries the request's address and its completion is returned to the requester. Otherwise the slot is filled with a dummy access to a fixed address, and nothing is returned.

The interval is captured when the session starts and stays frozen until reset. An epoch runs from the first counting cycle to the completion of its access: the block counts `I` idle cycles, launches in the next cycle, then waits for the resource to signal completion. With a resource latency of `L` cycles from launch to completion, the epoch length is `E = I + L + 1`. Only one real request can be outstanding. The requester is held off with a low ready until its response has been delivered.

The controller has three named states. `ST_IDLE` is the state after reset and moves to `ST_COUNT` on `start_i`. `ST_COUNT` counts and moves to `ST_ACCESS` in the launch cycle, when the count equals the interval. `ST_ACCESS` moves back to `ST_COUNT` in the cycle the resource signals completion. Whether the current access is real or dummy is held internally. The launch pulse and the completion timing are the same for both kinds.

Top module: `pubint_sched`

## Requirements
- R1: After reset the block is idle: `req_ready_o`, `mem_start_o` and `rsp_valid_o` are all low until a session is started.
- R2: If `start_i` is high in cycle S while idle, the interval is captured from `interval_i`, and the first launch (`mem_start_o` high for one cycle) occurs in cycle S+1+I.
- R3: If the resource completes (`mem_done_i` high) in cycle D, the next launch occurs in cycle D+1+I. With latency L, successive launches are therefore exactly I+L+1 cycles apart.
- R4: A launch happens in every epoch even when no request is waiting. Such a dummy launch drives `mem_addr_o` to the parameter `DUMMY_ADDR`, and its completion raises no `rsp_valid_o`.
- R5: A request that is pending in the launch cycle makes that access real: `mem_addr_o` equals the request's address in the launch cycle, and `rsp_valid_o` is high in exactly the cycle that access completes.
- R6: A request accepted in cycle D+1+i after a completion in cycle D, with i < I, is served in that same epoch, and its response appears in cycle D+E.
- R7: A request accepted in the launch cycle of an epoch (i = I) or later in that epoch misses that slot, which carries a dummy. Its response appears in the next epoch, in cycle D+2E.
- R8: `req_ready_o` is low from the cycle after a request is accepted through the cycle of its response, and high again in the following cycle.
- R9: Changes to `interval_i` while a session is running have no effect on the launch schedule.
- R10: With an interval of zero, each launch occurs in the cycle right after the previous completion, so accesses run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins the session and captures the interval; ignored once running |
| interval_i | input | CNT_W | Idle cycles between a completion and the next launch |
| req_valid_i | input | 1 | Requester has an access to issue |
| req_addr_i | input | ADDR_W | Address of the requested access |
| req_ready_o | output | 1 | Block can accept a request this cycle |
| rsp_valid_o | output | 1 | The requester's real access completed this cycle |
| mem_start_o | output | 1 | One-cycle launch of a resource access |
| mem_addr_o | output | ADDR_W | Address of the access being launched |
| mem_done_i | input | 1 | Resource signals completion of the launched access |

## Verification
The assertions assume the resource is well behaved. It raises `mem_done_i` for a single cycle only while an access is in flight, and only at least one cycle after that access was launched. The interval-window check counts cycles in the checker rather than using a parameter-sized delay. The bench's resource model answers every launch with one completion pulse a fixed two cycles later, and never completes outside an access, so the stimulus stays inside these assumptions. Requests are offered only from the cycle after a completion, at offsets chosen to fall either before or at the launch cycle.

// File: rtl/pubint_pkg.sv
package pubint_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_ACCESS = 2'd2
    } sched_state_t;

endpackage

// File: rtl/pubint_timer.sv
// Interval counter: holds the captured interval and flags the launch cycle.
module pubint_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] ivl_in,
    input  logic             en,
    output logic             hit
);
    logic [CNT_W-1:0] ivl_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivl_q <= '0;
        end else if (load) begin
            ivl_q <= ivl_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || hit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = en && (cnt_q == ivl_q);
endmodule

// File: rtl/pubint_slot_hold.sv
// Holds the single outstanding request: waiting for a slot, then in flight.
module pubint_slot_hold #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              launch,
    input  logic              retire,
    output logic              waiting,
    output logic              in_flight,
    output logic [ADDR_W-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting   <= 1'b0;
            in_flight <= 1'b0;
            addr_q    <= '0;
        end else begin
            if (accept) begin
                waiting <= 1'b1;
                addr_q  <= addr_in;
            end else if (launch && waiting) begin
                waiting   <= 1'b0;
                in_flight <= 1'b1;
            end
            if (retire) begin
                in_flight <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pubint_sched.sv
module pubint_sched #(
    parameter int                ADDR_W     = 16,
    parameter int                CNT_W      = 8,
    parameter logic [ADDR_W-1:0] DUMMY_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  interval_i,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              req_ready_o,
    output logic              rsp_valid_o,
    output logic              mem_start_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_done_i
);
    import pubint_pkg::*;

    sched_state_t      state_q, state_d;
    logic              hit;
    logic              launch;
    logic              accept;
    logic              retire;
    logic              waiting;
    logic              in_flight;
    logic [ADDR_W-1:0] held_addr;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)    state_d = ST_COUNT;
            ST_COUNT:  if (hit)        state_d = ST_ACCESS;
            ST_ACCESS: if (mem_done_i) state_d = ST_COUNT;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        launch      = 1'b0;
        retire      = 1'b0;
        req_ready_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready_o = 1'b0;
            end
            ST_COUNT: begin
                launch      = hit;
                req_ready_o = !waiting && !in_flight;
            end
            ST_ACCESS: begin
                retire      = mem_done_i && in_flight;
                req_ready_o = !waiting && !in_flight;
            end
            default: begin
                req_ready_o = 1'b0;
            end
        endcase
        accept      = req_valid_i && req_ready_o;
        mem_start_o = launch;
        mem_addr_o  = (launch && waiting) ? held_addr : DUMMY_ADDR;
        rsp_valid_o = retire;
    end

    pubint_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (state_q == ST_IDLE && start_i),
        .ivl_in (interval_i),
        .en     (state_q == ST_COUNT),
        .hit    (hit)
    );

    pubint_slot_hold #(.ADDR_W(ADDR_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .addr_in   (req_addr_i),
        .launch    (launch),
        .retire    (retire),
        .waiting   (waiting),
        .in_flight (in_flight),
        .addr_q    (held_addr)
    );
endmodule

// File: rtl/pubint_sched_chk.sv
module pubint_sched_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [CNT_W-1:0]  interval_i,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic              rsp_valid_o,
    input logic              mem_start_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_done_i
);
    logic             run_q;
    logic             busy_q;
    logic [CNT_W-1:0] gap_q;
    logic [CNT_W-1:0] ivl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            busy_q <= 1'b0;
            gap_q  <= '0;
            ivl_q  <= '0;
        end else if (!run_q) begin
            if (start_i) begin
                run_q <= 1'b1;
                ivl_q <= interval_i;
                gap_q <= '0;
            end
        end else begin
            if (mem_start_o) busy_q <= 1'b1;
            if (mem_done_i) begin
                busy_q <= 1'b0;
                gap_q  <= '0;
            end else if (!busy_q && !mem_start_o && gap_q != '1) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (!mem_start_o && !req_ready_o && !rsp_valid_o));

    // R3
    launch_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_start_o |-> (run_q && !busy_q && gap_q == ivl_q));

    // R3
    single_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_start_o |=> !mem_start_o);

    // R3
    done_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_done_i |-> busy_q);

    // R5
    rsp_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> mem_done_i);

    // R8
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    // R8
    rsp_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> !req_ready_o);

    // R8
    ready_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> req_ready_o);

    logic unused_addr;
    assign unused_addr = ^mem_addr_o;
endmodule

bind pubint_sched pubint_sched_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .interval_i  (interval_i),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .rsp_valid_o (rsp_valid_o),
    .mem_start_o (mem_start_o),
    .mem_addr_o  (mem_addr_o),
    .mem_done_i  (mem_done_i)
);

// File: tb/tb_pubint_sched.sv
`timescale 1ns/1ps
module tb_pubint_sched;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 8;
    localparam logic [ADDR_W-1:0] DUMMY = 16'hD00D;
    localparam int LAT = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [CNT_W-1:0]  interval_i = '0;
    logic              req_valid_i = 1'b0;
    logic [ADDR_W-1:0] req_addr_i = '0;
    logic              req_ready_o;
    logic              rsp_valid_o;
    logic              mem_start_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic              mem_done_i;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int n_rsp = 0;
    logic [ADDR_W-1:0] last_launch_addr = '0;
    logic [7:0] lat_cnt;

    always #4 clk = ~clk;

    pubint_sched #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DUMMY_ADDR(DUMMY)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .interval_i(interval_i),
        .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .req_ready_o(req_ready_o),
        .rsp_valid_o(rsp_valid_o), .mem_start_o(mem_start_o), .mem_addr_o(mem_addr_o),
        .mem_done_i(mem_done_i)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Resource model: one completion pulse LAT cycles after each launch
    always @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt    <= '0;
            mem_done_i <= 1'b0;
        end else begin
            mem_done_i <= 1'b0;
            if (mem_start_o) begin
                lat_cnt <= 8'(LAT - 1);
            end else if (lat_cnt != 0) begin
                lat_cnt <= lat_cnt - 1'b1;
                if (lat_cnt == 1) mem_done_i <= 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && mem_start_o) last_launch_addr <= mem_addr_o;
        if (rst_n && rsp_valid_o) n_rsp <= n_rsp + 1;
    end

    always @(posedge clk) begin
        if (cyc == 20000) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; start_i = 1'b0; req_valid_i = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // returns the start cycle
    task automatic do_start(input int ivl, output int s);
        @(posedge clk); #1;
        interval_i = CNT_W'(ivl);
        start_i = 1'b1;
        s = cyc;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic wait_launch(output int c, output logic [ADDR_W-1:0] a);
        c = -1; a = '0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (mem_start_o) begin c = cyc; a = mem_addr_o; break; end
        end
    endtask

    task automatic wait_done(output int d);
        d = -1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (mem_done_i) begin d = cyc; break; end
        end
    endtask

    task automatic wait_rsp(output int r);
        r = -1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (rsp_valid_o) begin r = cyc; break; end
        end
    endtask

    task automatic t_reset();
        do_reset();
        repeat (4) @(negedge clk);
        chk("R1 ready", int'(req_ready_o), 0);
        chk("R1 launch", int'(mem_start_o), 0);
        chk("R1 rsp", int'(rsp_valid_o), 0);
    endtask

    task automatic t_dummy();
        int s, c1, c2, r0;
        logic [ADDR_W-1:0] a;
        do_reset();
        do_start(3, s);
        r0 = n_rsp;
        wait_launch(c1, a);
        chk("R2 first launch cycle", c1, s + 1 + 3);
        chk("R4 dummy addr", int'(a), int'(DUMMY));
        wait_launch(c2, a);
        chk("R3 launch spacing", c2 - c1, 3 + LAT + 1);
        chk("R4 no rsp for dummy", n_rsp - r0, 0);
    endtask

    task automatic t_early();
        int d, r;
        wait_done(d);
        @(posedge clk); #1;
        @(posedge clk); #1;
        req_valid_i = 1'b1; req_addr_i = 16'h1234;
        @(negedge clk);
        chk("R6 ready at offer", int'(req_ready_o), 1);
        @(posedge clk); #1;
        req_valid_i = 1'b0;
        @(negedge clk);
        chk("R8 ready low after accept", int'(req_ready_o), 0);
        wait_rsp(r);
        chk("R6 rsp cycle", r, d + 6);
        chk("R5 real addr", int'(last_launch_addr), 16'h1234);
        chk("R8 ready low in rsp cycle", int'(req_ready_o), 0);
        @(negedge clk);
        chk("R8 ready after rsp", int'(req_ready_o), 1);
    endtask

    task automatic t_late();
        int d, r;
        wait_done(d);
        @(posedge clk); #1;
        repeat (3) begin @(posedge clk); #1; end
        req_valid_i = 1'b1; req_addr_i = 16'h0BEE;
        @(negedge clk);
        chk("R7 launch in offer cycle", int'(mem_start_o), 1);
        chk("R7 missed slot is dummy", int'(mem_addr_o), int'(DUMMY));
        chk("R7 accepted", int'(req_ready_o), 1);
        @(posedge clk); #1;
        req_valid_i = 1'b0;
        wait_rsp(r);
        chk("R7 rsp cycle", r, d + 12);
        chk("R7 served next epoch addr", int'(last_launch_addr), 16'h0BEE);
    endtask

    task automatic t_ignore();
        int c1, c2;
        logic [ADDR_W-1:0] a;
        @(posedge clk); #1;
        interval_i = 8'd9;
        wait_launch(c1, a);
        wait_launch(c2, a);
        chk("R9 spacing unchanged", c2 - c1, 3 + LAT + 1);
        interval_i = 8'd3;
    endtask

    task automatic t_zero();
        int s, c1, c2, d;
        logic [ADDR_W-1:0] a;
        do_reset();
        do_start(0, s);
        wait_launch(c1, a);
        chk("R10 first launch", c1, s + 1);
        wait_done(d);
        wait_launch(c2, a);
        chk("R10 back to back", c2, d + 1);
        chk("R10 spacing", c2 - c1, LAT + 1);
    endtask

    initial begin
        t_reset();
        t_dummy();
        t_early();
        t_late();
        t_ignore();
        t_zero();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule